// File: doc/BRIEF.md
# UART Prioritized Interrupt Identification Unit

This block collects every interrupt condition of a UART into one prioritized identification code and one interrupt line. It handles six causes: receive line errors, receive idle timeout, receive data at the trigger level, transmit ready, modem status change, and a rising edge on the automatic flow-control pins. Each cause has an enable bit. Enabled causes are masked first and then ranked. The code output always shows only the highest-ranked enabled cause. The causes below it stay pending and show up once the reported one is serviced.

The other parts of the UART drive its inputs. The receiver and transmitter supply error pulses, FIFO fill levels and a one-per-bit-time tick. The modem logic supplies delta pulses and the flow-control pin states. The register decoder supplies single-cycle strobes for reads of the line status, modem status, receive data and identification registers, and for writes of transmit data. Each cause is cleared by its own access event. The receive-ready cause is the exception: it is a live comparison, and it goes away only when the FIFO level falls below the trigger.

Top module: `uart_irq_id`

## Requirements
- R1: After reset, `irq_id` is 0x01 and `irq` is 0. The enable input, not the reset, decides which causes are unmasked.
- R2: Ranking from highest to lowest is: line status, receive timeout, receive ready, transmit ready, modem status, flow-control change. `irq_id` shows only the highest enabled pending cause.
- R3: Codes are: line status 0x06, receive timeout 0x0C, receive ready 0x04, transmit ready 0x02, modem status 0x00, flow-control change 0x20, nothing pending 0x01. `irq` is 1 exactly when `irq_id` is not 0x01.
- R4: Any bit of `lsr_err` makes the line status cause pending. A `lsr_rd` strobe clears it. It is enabled by `ien[2]`.
- R5: The receive ready cause is active while `rx_level >= rx_trig`, with no delay. It stays active until the level drops below the trigger. It is enabled by `ien[0]`.
- R6: The receive timeout cause becomes pending one cycle after 4*CHAR_BITS+12 `bit_tick` pulses have counted while `rx_level` is nonzero. The count restarts on every `rx_push` and every `rx_pop`. A `rx_pop` clears the pending cause. It is enabled by `ien[0]`.
- R7: The transmit ready cause becomes pending on the cycle where (`tx_level <= tx_trig` or `tx_level == 0`) becomes true. A `thr_wr` clears it. An `iir_rd` also clears it, but only when `irq_id` is 0x02 in that cycle. It is enabled by `ien[1]`.
- R8: Any bit of `msr_delta` makes the modem status cause pending. A `msr_rd` strobe clears it. It is enabled by `ien[3]`.
- R9: A low-to-high change on `cts_pin` while `auto_cts` is 1 makes the CTS cause pending. A low-to-high change on `rts_pin` while `auto_rts` is 1 makes the RTS cause pending. A rise while the automatic mode is off is ignored. A `msr_rd` strobe clears both. They are enabled by `ien[7]` (CTS) and `ien[6]` (RTS), and each also needs `enh_en` = 1.
- R10: A disabled cause still latches. Setting its enable bit later makes it visible without a new event. `ien[5:4]` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ien | input | 8 | Cause enables: [0] receive, [1] transmit, [2] line status, [3] modem, [6] RTS, [7] CTS |
| enh_en | input | 1 | Enhanced-feature bit that gates the flow-control causes |
| lsr_err | input | 4 | Overrun, parity, framing and break error pulses |
| lsr_rd | input | 1 | Line status register read strobe |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Receive trigger level |
| rx_push | input | 1 | A character entered the receive FIFO |
| rx_pop | input | 1 | Receive data register read strobe |
| bit_tick | input | 1 | One pulse per serial bit time |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_trig | input | LVL_W | Transmit trigger level |
| thr_wr | input | 1 | Transmit data register write strobe |
| iir_rd | input | 1 | Identification register read strobe |
| msr_delta | input | 4 | Modem status change pulses |
| msr_rd | input | 1 | Modem status register read strobe |
| auto_cts | input | 1 | Automatic CTS flow control active |
| auto_rts | input | 1 | Automatic RTS flow control active |
| cts_pin | input | 1 | CTS pin state |
| rts_pin | input | 1 | RTS pin state |
| irq_id | output | 6 | Identification code of the highest enabled pending cause |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with CHAR_BITS = 7 and FIFO_DEPTH = 8. This gives a 40-tick timeout window, so each directed task can count the whole window, one tick short of it, and a restart in the middle of it. The 4-bit levels let the receive and transmit trigger comparisons be driven across their thresholds in both directions. The other tasks stack several causes at once to check the ranking. They check that an identification read leaves transmit ready pending behind a higher cause, and that flow-control rises are ignored outside automatic mode.

// File: rtl/uart_irq_pkg.sv
// Package: identification codes and cause indices shared by the interrupt unit.
// Assumes cause index 0 is the highest priority.
package uart_irq_pkg;
    localparam int NUM_SRC = 6;
    localparam int ID_W    = 6;

    localparam logic [ID_W-1:0] ID_NONE = 6'h01;
    localparam logic [ID_W-1:0] ID_LSR  = 6'h06;
    localparam logic [ID_W-1:0] ID_TOUT = 6'h0C;
    localparam logic [ID_W-1:0] ID_RDY  = 6'h04;
    localparam logic [ID_W-1:0] ID_TX   = 6'h02;
    localparam logic [ID_W-1:0] ID_MSR  = 6'h00;
    localparam logic [ID_W-1:0] ID_FLOW = 6'h20;

    typedef enum logic [2:0] {
        SRC_LSR  = 3'd0,
        SRC_TOUT = 3'd1,
        SRC_RDY  = 3'd2,
        SRC_TX   = 3'd3,
        SRC_MSR  = 3'd4,
        SRC_FLOW = 3'd5
    } src_e;

    // Map a cause index to its identification code.
    function automatic logic [ID_W-1:0] src_code(input int idx);
        case (idx)
            0:       return ID_LSR;
            1:       return ID_TOUT;
            2:       return ID_RDY;
            3:       return ID_TX;
            4:       return ID_MSR;
            default: return ID_FLOW;
        endcase
    endfunction
endpackage

// File: rtl/uart_irq_rx_timer.sv
// Receive idle timer: counts bit ticks while the receive FIFO is non-empty and
// raises a sticky timeout flag after 4*CHAR_BITS+12 ticks.
// Assumes bit_tick is a single-cycle pulse per bit time; push/pop restart the count.
module uart_irq_rx_timer #(
    parameter int CHAR_BITS = 10,
    parameter int LVL_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             bit_tick,
    output logic             tout_pend
);
    localparam int LIMIT = 4 * CHAR_BITS + 12;
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt;

    // Idle counter: restart on FIFO activity or empty FIFO, saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cnt <= '0;
        else if (rx_push || rx_pop)              cnt <= '0;
        else if (rx_level == '0)                 cnt <= '0;
        else if (bit_tick && cnt != LIMIT_C)     cnt <= cnt + 1'b1;
    end

    // Sticky timeout flag: set at the limit, cleared only by a data read.
    always_ff @(posedge clk) begin
        if (!rst_n)               tout_pend <= 1'b0;
        else if (rx_pop)          tout_pend <= 1'b0;
        else if (cnt == LIMIT_C)  tout_pend <= 1'b1;
    end

    // R6
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT_C);

    // R6
    tout_needs_full_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tout_pend) |-> $past(cnt) == LIMIT_C);

    // R6
    tout_clear_on_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> !tout_pend);
endmodule

// File: rtl/uart_irq_sources.sv
// Event-latched causes: line status, transmit ready, modem status, CTS and RTS rises.
// Each pending bit is set by its event and cleared by its access strobe; a set
// in the same cycle as a clear wins. Assumes strobes are single-cycle.
module uart_irq_sources #(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       lsr_err,
    input  logic             lsr_rd,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] tx_trig,
    input  logic             thr_wr,
    input  logic             tx_id_ack,
    input  logic [3:0]       msr_delta,
    input  logic             msr_rd,
    input  logic             auto_cts,
    input  logic             auto_rts,
    input  logic             cts_pin,
    input  logic             rts_pin,
    output logic             lsr_pend,
    output logic             tx_pend,
    output logic             msr_pend,
    output logic             cts_pend,
    output logic             rts_pend
);
    logic tx_cond, tx_cond_q, tx_evt;
    logic cts_q, rts_q, cts_rise, rts_rise;
    logic lsr_evt, msr_evt;

    // Event detection: error/delta reductions, transmit threshold entry, pin rises.
    always_comb begin
        lsr_evt  = |lsr_err;
        msr_evt  = |msr_delta;
        tx_cond  = (tx_level <= tx_trig) || (tx_level == '0);
        tx_evt   = tx_cond && !tx_cond_q;
        cts_rise = auto_cts && cts_pin && !cts_q;
        rts_rise = auto_rts && rts_pin && !rts_q;
    end

    // Edge history: previous threshold and pin states (start high to avoid reset events).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_cond_q <= 1'b1;
            cts_q     <= 1'b1;
            rts_q     <= 1'b1;
        end else begin
            tx_cond_q <= tx_cond;
            cts_q     <= cts_pin;
            rts_q     <= rts_pin;
        end
    end

    // Pending latches: set by event, cleared by own access strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lsr_pend <= 1'b0;
            tx_pend  <= 1'b0;
            msr_pend <= 1'b0;
            cts_pend <= 1'b0;
            rts_pend <= 1'b0;
        end else begin
            lsr_pend <= lsr_evt  | (lsr_pend & ~lsr_rd);
            tx_pend  <= tx_evt   | (tx_pend  & ~(thr_wr | tx_id_ack));
            msr_pend <= msr_evt  | (msr_pend & ~msr_rd);
            cts_pend <= cts_rise | (cts_pend & ~msr_rd);
            rts_pend <= rts_rise | (rts_pend & ~msr_rd);
        end
    end

    // R4
    lsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && lsr_err == 4'b0) |=> !lsr_pend);

    // R7
    tx_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !(tx_level <= tx_trig || tx_level == '0)) |=> !tx_pend);

    // R9
    flow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && !auto_cts && !auto_rts) |=> (!cts_pend && !rts_pend));

    // R9
    cts_manual_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_cts && !cts_pend) |=> !cts_pend);
endmodule

// File: rtl/uart_irq_prio.sv
// Priority encoder: picks the lowest-index set request and emits its code.
// Assumes index 0 is the highest priority; an empty request gives the idle code.
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0]    req,
    output logic [ID_W-1:0] code
);
    // Scan from lowest to highest priority so the highest set request wins.
    always_comb begin
        code = ID_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) code = src_code(i);
        end
    end
endmodule

// File: rtl/uart_irq_id.sv
// UART interrupt identification top: masks every cause with its enable bit,
// ranks the survivors and drives the code and interrupt line.
// Assumes all inputs are synchronous to clk and strobes are one cycle wide.
module uart_irq_id
    import uart_irq_pkg::*;
#(
    parameter int CHAR_BITS  = 10,
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       ien,
    input  logic             enh_en,
    input  logic [3:0]       lsr_err,
    input  logic             lsr_rd,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trig,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             bit_tick,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] tx_trig,
    input  logic             thr_wr,
    input  logic             iir_rd,
    input  logic [3:0]       msr_delta,
    input  logic             msr_rd,
    input  logic             auto_cts,
    input  logic             auto_rts,
    input  logic             cts_pin,
    input  logic             rts_pin,
    output logic [5:0]       irq_id,
    output logic             irq
);
    logic tout_pend, lsr_pend, tx_pend, msr_pend, cts_pend, rts_pend;
    logic tx_id_ack;
    logic [NUM_SRC-1:0] req;
    logic [ID_W-1:0]    code;

    uart_irq_rx_timer #(.CHAR_BITS(CHAR_BITS), .LVL_W(LVL_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rx_push(rx_push),
        .rx_pop(rx_pop), .bit_tick(bit_tick), .tout_pend(tout_pend)
    );

    uart_irq_sources #(.LVL_W(LVL_W)) u_src (
        .clk(clk), .rst_n(rst_n), .lsr_err(lsr_err), .lsr_rd(lsr_rd),
        .tx_level(tx_level), .tx_trig(tx_trig), .thr_wr(thr_wr),
        .tx_id_ack(tx_id_ack), .msr_delta(msr_delta), .msr_rd(msr_rd),
        .auto_cts(auto_cts), .auto_rts(auto_rts), .cts_pin(cts_pin),
        .rts_pin(rts_pin), .lsr_pend(lsr_pend), .tx_pend(tx_pend),
        .msr_pend(msr_pend), .cts_pend(cts_pend), .rts_pend(rts_pend)
    );

    // Masking: each cause gated by its enable before ranking.
    always_comb begin
        req           = '0;
        req[SRC_LSR]  = lsr_pend  & ien[2];
        req[SRC_TOUT] = tout_pend & ien[0];
        req[SRC_RDY]  = (rx_level >= rx_trig) & ien[0];
        req[SRC_TX]   = tx_pend   & ien[1];
        req[SRC_MSR]  = msr_pend  & ien[3];
        req[SRC_FLOW] = enh_en & ((cts_pend & ien[7]) | (rts_pend & ien[6]));
    end

    uart_irq_prio #(.N(NUM_SRC)) u_prio (.req(req), .code(code));

    // Output drive and transmit acknowledge on an identification read that reports it.
    always_comb begin
        irq_id    = code;
        irq       = (code != ID_NONE);
        tx_id_ack = iir_rd && (code == ID_TX);
    end

    // R2
    lsr_top_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_pend && ien[2]) |-> irq_id == ID_LSR);

    // R3
    irq_matches_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|req));

    // R7
    tx_kept_behind_higher_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pend && iir_rd && irq_id != ID_TX) |=> tx_pend);
endmodule

// File: tb/tb_uart_irq_id.sv
module tb_uart_irq_id;
    localparam int CB  = 7;
    localparam int FD  = 8;
    localparam int LW  = $clog2(FD + 1);
    localparam int LIM = 4 * CB + 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] ien = '0;
    logic enh_en = 1'b0;
    logic [3:0] lsr_err = '0;
    logic lsr_rd = 1'b0;
    logic [LW-1:0] rx_level = '0, rx_trig = LW'(4), tx_level = '0, tx_trig = LW'(2);
    logic rx_push = 1'b0, rx_pop = 1'b0, bit_tick = 1'b0, thr_wr = 1'b0, iir_rd = 1'b0;
    logic [3:0] msr_delta = '0;
    logic msr_rd = 1'b0, auto_cts = 1'b0, auto_rts = 1'b0, cts_pin = 1'b0, rts_pin = 1'b0;
    logic [5:0] irq_id;
    logic irq;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    uart_irq_id #(.CHAR_BITS(CB), .FIFO_DEPTH(FD)) dut (
        .clk(clk), .rst_n(rst_n), .ien(ien), .enh_en(enh_en), .lsr_err(lsr_err),
        .lsr_rd(lsr_rd), .rx_level(rx_level), .rx_trig(rx_trig), .rx_push(rx_push),
        .rx_pop(rx_pop), .bit_tick(bit_tick), .tx_level(tx_level), .tx_trig(tx_trig),
        .thr_wr(thr_wr), .iir_rd(iir_rd), .msr_delta(msr_delta), .msr_rd(msr_rd),
        .auto_cts(auto_cts), .auto_rts(auto_rts), .cts_pin(cts_pin), .rts_pin(rts_pin),
        .irq_id(irq_id), .irq(irq)
    );

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic chk_id(input string req, input logic [5:0] exp);
        chk(req, irq_id, exp);
        chk(req, {5'b0, irq}, {5'b0, exp != 6'h01});
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // R1: reset state
    task automatic t_reset();
        chk_id("R1 reset", 6'h01);
    endtask

    // R4: line status set and clear, R10 masking and ignored bits
    task automatic t_lsr();
        ien = 8'h30;                          // only ignored bits R10
        lsr_err = 4'b0100; step(); lsr_err = '0;
        chk_id("R10 masked lsr", 6'h01);
        ien = 8'h04; #1;
        chk_id("R10 late enable lsr", 6'h06);
        lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
        chk_id("R4 lsr cleared", 6'h01);
        lsr_err = 4'b0001; step(); lsr_err = '0;
        chk_id("R4 overrun", 6'h06);
        lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
        ien = 8'h00;
    endtask

    // R5: receive ready follows level vs trigger
    task automatic t_rdy();
        ien = 8'h01; rx_trig = LW'(4);
        rx_level = LW'(4); #1;
        chk_id("R5 at trigger", 6'h04);
        rx_level = LW'(3); #1;
        chk_id("R5 below trigger", 6'h01);
        rx_level = '0; step();
        ien = 8'h00;
    endtask

    // R6: timeout window, restart on push, clear on pop
    task automatic t_tout();
        ien = 8'h01; rx_trig = LW'(4);
        rx_level = LW'(1); rx_push = 1'b1; step(); rx_push = 1'b0;
        bit_tick = 1'b1;
        repeat (30) step();
        bit_tick = 1'b0; rx_push = 1'b1; rx_level = LW'(2); step(); rx_push = 1'b0;
        bit_tick = 1'b1;
        repeat (LIM - 1) step();
        chk_id("R6 one tick short after restart", 6'h01);
        step(); bit_tick = 1'b0;
        chk_id("R6 flag lags count", 6'h01);
        step();
        chk_id("R6 timeout", 6'h0C);
        rx_pop = 1'b1; rx_level = LW'(1); step(); rx_pop = 1'b0;
        chk_id("R6 pop clears", 6'h01);
        rx_pop = 1'b1; rx_level = '0; step(); rx_pop = 1'b0;
        ien = 8'h00;
    endtask

    // R7: transmit ready, cleared by id read when reported, or by data write
    task automatic t_tx();
        ien = 8'h02;
        tx_level = LW'(5); step();
        chk_id("R7 above trigger", 6'h01);
        tx_level = LW'(2); step();
        chk_id("R7 trigger reached", 6'h02);
        iir_rd = 1'b1; step(); iir_rd = 1'b0;
        chk_id("R7 id read clears", 6'h01);
        tx_level = LW'(6); step(); tx_level = '0; step();
        chk_id("R7 empty", 6'h02);
        tx_level = LW'(6); thr_wr = 1'b1; step(); thr_wr = 1'b0;
        chk_id("R7 write clears", 6'h01);
        // id read returning a higher cause keeps tx pending
        ien = 8'h06;
        tx_level = LW'(1); lsr_err = 4'b1000; step(); lsr_err = '0;
        chk_id("R2 lsr over tx", 6'h06);
        iir_rd = 1'b1; step(); iir_rd = 1'b0;
        chk_id("R7 id read of lsr", 6'h06);
        lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
        chk_id("R7 tx still pending", 6'h02);
        thr_wr = 1'b1; tx_level = LW'(6); step(); thr_wr = 1'b0;
        ien = 8'h00;
    endtask

    // R8: modem status
    task automatic t_msr();
        ien = 8'h08;
        msr_delta = 4'b0010; step(); msr_delta = '0;
        chk_id("R8 modem", 6'h00);
        msr_rd = 1'b1; step(); msr_rd = 1'b0;
        chk_id("R8 modem cleared", 6'h01);
        ien = 8'h00;
    endtask

    // R9: flow-control rises
    task automatic t_flow();
        ien = 8'hC0; enh_en = 1'b0;
        cts_pin = 1'b1; step();              // manual mode rise: ignored
        cts_pin = 1'b0; enh_en = 1'b1; step();
        chk_id("R9 manual rise ignored", 6'h01);
        enh_en = 1'b0; auto_cts = 1'b1;
        cts_pin = 1'b1; step();
        chk_id("R9 needs enhanced bit", 6'h01);
        enh_en = 1'b1; #1;
        chk_id("R9 cts rise", 6'h20);
        msr_rd = 1'b1; step(); msr_rd = 1'b0;
        chk_id("R9 cleared by modem read", 6'h01);
        auto_rts = 1'b1; rts_pin = 1'b1; step();
        chk_id("R9 rts rise", 6'h20);
        ien = 8'h80; #1;
        chk_id("R9 rts masked by its enable", 6'h01);
        msr_rd = 1'b1; step(); msr_rd = 1'b0;
        auto_cts = 1'b0; auto_rts = 1'b0; cts_pin = 1'b0; rts_pin = 1'b0; enh_en = 1'b0;
        ien = 8'h00; step();
    endtask

    // R2/R3: stacked causes served in rank order
    task automatic t_prio();
        ien = 8'hCF; enh_en = 1'b1; auto_cts = 1'b1;
        lsr_err = 4'b0010; msr_delta = 4'b0001; cts_pin = 1'b1; rx_level = LW'(4);
        step(); lsr_err = '0; msr_delta = '0;
        chk_id("R2 lsr first", 6'h06);
        lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
        chk_id("R2 ready next", 6'h04);
        rx_level = LW'(3); #1;
        chk_id("R3 modem code", 6'h00);
        msr_rd = 1'b1; step(); msr_rd = 1'b0;
        chk_id("R3 idle after all", 6'h01);
        rx_level = '0; cts_pin = 1'b0; auto_cts = 1'b0; enh_en = 1'b0; ien = 8'h00;
        step();
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_lsr();
        t_rdy();
        t_tout();
        t_tx();
        t_msr();
        t_flow();
        t_prio();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule